// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register Front End

This block is the digital side of a serial-input digital-to-analog converter. A host shifts 16-bit words into it over a three-wire serial link (serial clock, active-low frame select, serial data). The low `DATA_W` bits of each word form the converter code; the rest of the word is discarded. The code passes first into a holding register and then into the code register that drives the converter. The code register is written at the end of the frame or later by an active-low load strobe, depending on the level of that strobe when the frame closes.

An active-low clear input puts the output into a cleared state without changing any stored code. A power-down input is passed out as a flag. One 16-bit shift register serves two purposes on the serial output. It can pass the written words through to the next device in a chain. It can also return the current code to the host when the active-low readback enable is used. All serial pins are asynchronous. They are resynchronised into a fast system clock, and the serial clock must run at no more than one quarter of that rate.

Top module: `dacif_top`

## Requirements
- R1: A frame starts on the falling edge of the frame select and ends on its rising edge. During the frame, serial data is sampled on each serial-clock falling edge, MSB first. A frame of exactly 16 bits that ends while the load strobe is low writes the low `DATA_W` bits of the word to `code_o` at once.
- R2: Word bits 15 down to `DATA_W` have no effect on `code_o`.
- R3: If the load strobe is high when a valid frame ends, `code_o` keeps its old value. The next falling edge of the load strobe copies that frame's code to `code_o`.
- R4: A frame that ends with a bit count other than 16 is dropped. It changes neither `code_o` nor the code that a later load strobe transfers.
- R5: While the clear input is low, `cleared_o` is 1 and `code_o` keeps its value.
- R6: If the load strobe is low when clear is released, `cleared_o` returns to 0 at once. Otherwise `cleared_o` stays 1 until the next load-strobe falling edge.
- R7: `powerdown_o` is 1 while the power-down input is low, and it does not change `code_o`.
- R8: With readback unused, the data bit sampled on serial-clock falling edge k appears on `sdo_o` after falling edge k+16. `sdo_o` changes only after a serial-clock falling edge.
- R9: After the readback enable falls, the next serial-clock falling edge loads {zeros, code} into the shift register. Each of the following 16 falling edges then presents one bit of that word on `sdo_o`, bit 15 first, and bits 15..DATA_W read 0.
- R10: After reset, `code_o` is 0, `cleared_o` is 1, `powerdown_o` is 0 and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock (idle high) |
| frame_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low load strobe |
| clr_n_i | input | 1 | Active-low clear |
| pd_n_i | input | 1 | Active-low power-down |
| rdbk_n_i | input | 1 | Active-low readback enable |
| code_o | output | DATA_W | Converter code register |
| cleared_o | output | 1 | Output forced to its cleared level |
| powerdown_o | output | 1 | Power-down flag |
| sdo_o | output | 1 | Serial data out (pass-through or readback) |

## Verification
The bench builds two instances from the same stimulus: one with the 14-bit default and one with `DATA_W` = 12. The 12-bit instance shows that the ignored upper bits vary with the width. The 14-bit instance reaches every path: immediate and deferred loads, short and long frames, both clear-release cases, pass-through and readback. A readback code with bit 13 set shows that the two padding bits stay zero.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef struct packed {
        logic sclk;
        logic frame_n;
        logic sdin;
        logic load_n;
        logic clr_n;
        logic pd_n;
        logic rdbk_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b1, frame_n: 1'b1, sdin: 1'b0,
                                    load_n: 1'b1, clr_n: 1'b1, pd_n: 1'b1,
                                    rdbk_n: 1'b1};

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int         W   = 7,
    parameter logic [W-1:0] RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] lvl;
        logic [W-1:0] old;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.meta = async_i;
        st_d.lvl  = st_q.meta;
        st_d.old  = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{meta: RST, lvl: RST, old: RST};
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
    assign prev_o  = st_q.old;
endmodule

// File: rtl/dacif_shift.sv
module dacif_shift #(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               shift_i,
    input  logic               rb_load_i,
    input  logic [FRAME_W-1:0] rb_word_i,
    input  logic               sdin_i,
    output logic [FRAME_W-1:0] word_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               sdo_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] word;
        logic [CNT_W-1:0]   cnt;
        logic               sdo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rb_load_i) begin
            st_d.word = rb_word_i;
        end else if (shift_i) begin
            st_d.sdo  = st_q.word[FRAME_W-1];
            st_d.word = {st_q.word[FRAME_W-2:0], sdin_i};
        end
        if (start_i)
            st_d.cnt = '0;
        else if (shift_i && !rb_load_i && st_q.cnt != CNT_SAT)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign count_o = st_q.cnt;
    assign sdo_o   = st_q.sdo;

    // R8
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i || rb_load_i) |=> $stable(sdo_o));
endmodule

// File: rtl/dacif_top.sv
module dacif_top #(
    parameter int DATA_W  = 14,
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              frame_n_i,
    input  logic              sdin_i,
    input  logic              load_n_i,
    input  logic              clr_n_i,
    input  logic              pd_n_i,
    input  logic              rdbk_n_i,
    output logic [DATA_W-1:0] code_o,
    output logic              cleared_o,
    output logic              powerdown_o,
    output logic              sdo_o
);
    import dacif_pkg::*;

    localparam int PAD_W = FRAME_W - DATA_W;
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    pins_t raw, cur, prev;
    assign raw = '{sclk: sclk_i, frame_n: frame_n_i, sdin: sdin_i,
                   load_n: load_n_i, clr_n: clr_n_i, pd_n: pd_n_i,
                   rdbk_n: rdbk_n_i};

    dacif_sync #(.W($bits(pins_t)), .RST(PINS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .level_o(cur), .prev_o(prev));

    logic sclk_fall, frame_start, frame_end, load_fall, clr_rise, rdbk_fall;
    assign sclk_fall   =  prev.sclk    & ~cur.sclk;
    assign frame_start =  prev.frame_n & ~cur.frame_n;
    assign frame_end   = ~prev.frame_n &  cur.frame_n;
    assign load_fall   =  prev.load_n  & ~cur.load_n;
    assign clr_rise    = ~prev.clr_n   &  cur.clr_n;
    assign rdbk_fall   =  prev.rdbk_n  & ~cur.rdbk_n;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] dac;
        logic              cleared;
        logic              rb_arm;
    } st_t;

    st_t st_d, st_q;

    logic               rb_load, shift_en, frame_ok;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   count;
    logic [DATA_W-1:0]  load_src;

    assign shift_en = sclk_fall & ~cur.frame_n;
    assign rb_load  = sclk_fall & st_q.rb_arm;

    dacif_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_i(frame_start), .shift_i(shift_en),
        .rb_load_i(rb_load), .rb_word_i({{PAD_W{1'b0}}, st_q.dac}),
        .sdin_i(cur.sdin),
        .word_o(word), .count_o(count), .sdo_o(sdo_o));

    assign frame_ok = frame_end && (count == CNT_FULL);
    assign load_src = frame_ok ? word[DATA_W-1:0] : st_q.hold;

    always_comb begin
        st_d = st_q;
        if (rdbk_fall)    st_d.rb_arm = 1'b1;
        else if (rb_load) st_d.rb_arm = 1'b0;

        if (frame_ok) begin
            st_d.hold = word[DATA_W-1:0];
            if (!cur.load_n) begin
                st_d.dac     = word[DATA_W-1:0];
                st_d.cleared = 1'b0;
            end
        end
        if (load_fall) begin
            st_d.dac     = load_src;
            st_d.cleared = 1'b0;
        end
        if (clr_rise && !cur.load_n) st_d.cleared = 1'b0;
        if (!cur.clr_n)              st_d.cleared = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hold: '0, dac: '0, cleared: 1'b1, rb_arm: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o      = st_q.dac;
    assign cleared_o   = st_q.cleared;
    assign powerdown_o = ~cur.pd_n;

    // R4
    bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && count != CNT_FULL && !load_fall) |=> $stable(code_o));
    // R3
    deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cur.load_n && !load_fall) |=> $stable(code_o));
    // R5
    clear_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur.clr_n && !prev.clr_n) |-> cleared_o);
    // R7
    pd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev.pd_n != cur.pd_n && !frame_end && !load_fall) |=> $stable(code_o));
endmodule

// File: tb/dacif_top_tb.sv
module dacif_top_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sclk, frame_n, sdin, load_n, clr_n, pd_n, rdbk_n;
    logic [13:0] code14;
    logic [11:0] code12;
    logic cl14, cl12, pd14, pd12, sdo14, sdo12;

    dacif_top u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n), .sdin_i(sdin),
        .load_n_i(load_n), .clr_n_i(clr_n), .pd_n_i(pd_n), .rdbk_n_i(rdbk_n),
        .code_o(code14), .cleared_o(cl14), .powerdown_o(pd14), .sdo_o(sdo14));

    dacif_top #(.DATA_W(12)) u_dut12 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n), .sdin_i(sdin),
        .load_n_i(load_n), .clr_n_i(clr_n), .pd_n_i(pd_n), .rdbk_n_i(rdbk_n),
        .code_o(code12), .cleared_o(cl12), .powerdown_o(pd12), .sdo_o(sdo12));

    int checks = 0;
    int fails  = 0;
    logic [15:0] cap;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic send_frame(input logic [15:0] w, input int nbits, output logic [15:0] c);
        c = '0;
        frame_n = 1'b0;
        waitc(4);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 16) ? w[15-i] : 1'b0;
            waitc(2);
            sclk = 1'b0;
            waitc(4);
            if (i < 16) c[15-i] = sdo14;
            sclk = 1'b1;
            waitc(4);
        end
        frame_n = 1'b1;
        waitc(6);
    endtask

    task automatic pulse_load;
        load_n = 1'b0; waitc(6);
        load_n = 1'b1; waitc(6);
    endtask

    task automatic t_reset;
        chk("R10 code", code14, 0);
        chk("R10 cleared", cl14, 1);
        chk("R10 powerdown", pd14, 0);
        chk("R10 sdo", sdo14, 0);
    endtask

    task automatic t_immediate;
        load_n = 1'b0; waitc(6);
        send_frame(16'h2ABC, 16, cap);
        chk("R1 code", code14, 32'h2ABC);
        chk("R1 cleared after load", cl14, 0);
        chk("R2 code12", code12, 32'hABC);
        send_frame(16'hFFFF, 16, cap);
        chk("R2 all ones", code14, 32'h3FFF);
        chk("R2 all ones 12", code12, 32'hFFF);
        send_frame(16'h4001, 16, cap);
        chk("R2 upper ignored", code14, 32'h0001);
        load_n = 1'b1; waitc(6);
    endtask

    task automatic t_deferred;
        send_frame(16'h1234, 16, cap);
        chk("R3 deferred hold", code14, 32'h0001);
        pulse_load;
        chk("R3 deferred load", code14, 32'h1234);
    endtask

    task automatic t_badframe;
        send_frame(16'h0777, 16, cap);
        chk("R3 deferred 2", code14, 32'h1234);
        send_frame(16'h3AAA, 17, cap);
        chk("R4 long frame", code14, 32'h1234);
        pulse_load;
        chk("R4 load after long", code14, 32'h0777);
        load_n = 1'b0; waitc(6);
        send_frame(16'h1111, 15, cap);
        chk("R4 short frame", code14, 32'h0777);
        load_n = 1'b1; waitc(6);
    endtask

    task automatic t_clear;
        clr_n = 1'b0; waitc(6);
        chk("R5 cleared", cl14, 1);
        chk("R5 code kept", code14, 32'h0777);
        clr_n = 1'b1; waitc(6);
        chk("R6 stays cleared", cl14, 1);
        pulse_load;
        chk("R6 load uncleared", cl14, 0);
        chk("R6 code", code14, 32'h0777);
        clr_n = 1'b0; waitc(6);
        load_n = 1'b0; waitc(6);
        chk("R5 cleared with load", cl14, 1);
        clr_n = 1'b1; waitc(6);
        chk("R6 release load low", cl14, 0);
        load_n = 1'b1; waitc(6);
    endtask

    task automatic t_pd;
        pd_n = 1'b0; waitc(6);
        chk("R7 powerdown", pd14, 1);
        chk("R7 code kept", code14, 32'h0777);
        pd_n = 1'b1; waitc(6);
        chk("R7 powerup", pd14, 0);
    endtask

    task automatic t_daisy;
        send_frame(16'hC35A, 16, cap);
        send_frame(16'h0F0F, 16, cap);
        chk("R8 passthrough", cap, 32'hC35A);
        chk("R8 code unchanged", code14, 32'h0777);
    endtask

    task automatic t_readback;
        load_n = 1'b0; waitc(6);
        send_frame(16'h3C96, 16, cap);
        load_n = 1'b1; waitc(6);
        chk("R1 code before readback", code14, 32'h3C96);
        rdbk_n = 1'b0; waitc(6);
        sclk = 1'b0; waitc(4);
        sclk = 1'b1; waitc(4);
        rdbk_n = 1'b1; waitc(4);
        send_frame(16'h0000, 16, cap);
        chk("R9 readback word", cap, 32'h3C96);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary;
        $finish;
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b1; frame_n = 1'b1; sdin = 1'b0;
        load_n = 1'b1; clr_n = 1'b1; pd_n = 1'b1; rdbk_n = 1'b1;
        waitc(5);
        rst_n = 1'b1;
        waitc(4);
        t_reset;
        t_immediate;
        t_deferred;
        t_badframe;
        t_clear;
        t_pd;
        t_daisy;
        t_readback;
        summary;
        $finish;
    end
endmodule